// File: doc/BRIEF.md
# Byte-Wide EEPROM Bus Sequencer

This block models the control side of a small byte-wide electrically erasable memory that is reached over an asynchronous-style bus. The bus has an 11-bit address, an 8-bit data path and three active-low strobes: chip select, output enable and write enable. All inputs are sampled on the block clock. Reads return the addressed byte. Writes are decoded from the strobe combination. The address is taken when the write window opens and the data when it closes. Accepted bytes are gathered in a one-page holding buffer.

When no byte strobe has arrived for a set number of clock cycles, the page is committed to the storage array in one timed programming cycle. While that cycle runs, a busy output pulls low. Reads return a status byte in place of array data. That byte carries an inverted copy of the top bit of the last accepted byte, a bit that flips on each read, and a bit that shows the load window has closed. The tri-state data bus is split into a data input, a data output and an output-drive enable. The busy line is given as the enable of an open-drain pull-down.

Top module: `eeprom_bus_seq`

## Requirements
- R1: After reset every array byte reads 8'hFF, `rdy_pull_low` is 0 and no page is pending.
- R2: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0 and `we_n`=1, and 0 whenever `ce_n` or `oe_n` is 1. Outside the programming cycle, `dout` then shows the array byte at `addr`.
- R3: A write window exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1. Strobes with `oe_n` low store nothing and start no programming.
- R4: The byte address is taken from `addr` in the first cycle both `ce_n` and `we_n` are low, whichever of them fell last. This holds for both write-strobe-led and chip-select-led cycles.
- R5: The data byte is taken from `din` in the first cycle the write window has closed, whichever of `ce_n` or `we_n` rose first.
- R6: A page is the 64 bytes sharing `addr[10:6]`. Bytes accepted while loading are committed together, and a repeated address keeps its last byte. Untouched bytes of the page keep their old contents. Reads during loading return the old array contents.
- R7: Programming starts after `LOAD_TIMEOUT` consecutive clock cycles with no write window open or closing, counted from the last window close. `rdy_pull_low` rises in the cycle after that count.
- R8: `rdy_pull_low` stays 1 for exactly `PROG_CYCLES` cycles. The array holds the new page once it drops.
- R9: While busy, a read shows the inverse of bit 7 of the last accepted byte on `dout[7]`, and 1 on `dout[5]`.
- R10: While busy, `dout[6]` inverts after every completed read.
- R11: While loading, a byte whose `addr[10:6]` differs from the loading page is discarded. Its window still restarts the load timeout.
- R12: Write windows during the programming cycle change neither the array nor the page being programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data from the bus |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| dout | output | 8 | Read data or busy status |
| dout_en | output | 1 | Data bus drive enable |
| rdy_pull_low | output | 1 | Open-drain busy pull-down enable |

## Verification
Table-driven writes alternate write-strobe-led and chip-select-led cycles. In each, the bus address and data are changed to other values right after the capture point, so an early or late capture shows up as a wrong byte or a wrong location. The table repeats an address, skips most of the page and includes a byte for a foreign page. Reading back the whole page then separates last-write-wins, unchanged bytes and the foreign-page discard. Directed tests look at the exact cycle busy starts and how long it lasts. They also cover status polling during busy, writes made while busy, writes with output enable low, and reads during loading.

// File: rtl/eeprom_bus_seq.sv
module eeprom_bus_seq #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 6,
  parameter int LOAD_TIMEOUT = 200,
  parameter int PROG_CYCLES  = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rdy_pull_low
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TAG_W      = ADDR_W - PAGE_W;
  localparam int LT_W       = $clog2(LOAD_TIMEOUT + 1);
  localparam int PC_W       = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} state_t;

  state_t            state;
  logic [DATA_W-1:0] mem   [DEPTH];
  logic [DATA_W-1:0] pbuf  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] last_q;
  logic [LT_W-1:0]   tmr;
  logic [PC_W-1:0]   pc;
  logic              wr_q, rd_q, tog_q;

  wire wr_act   = ~ce_n & ~we_n & oe_n;
  wire rd_act   = ~ce_n & ~oe_n & we_n;
  wire wr_start = wr_act & ~wr_q;
  wire wr_end   = ~wr_act & wr_q;
  wire rd_end   = ~rd_act & rd_q;
  wire busy     = (state == S_PROG);
  wire [PAGE_W-1:0] slot = addr_q[PAGE_W-1:0];

  assign dout_en      = rd_act;
  assign rdy_pull_low = busy;
  assign dout = busy ? {~last_q[DATA_W-1], tog_q, 1'b1, last_q[DATA_W-4:0]}
                     : mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      tog_q  <= 1'b0;
      addr_q <= '0;
      tag_q  <= '0;
      last_q <= '0;
      tmr    <= '0;
      pc     <= '0;
      pvalid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_start) addr_q <= addr;
      if (busy && rd_end) tog_q <= ~tog_q;
      case (state)
        S_IDLE: begin
          if (wr_end) begin
            tag_q        <= addr_q[ADDR_W-1:PAGE_W];
            pbuf[slot]   <= din;
            pvalid       <= '0;
            pvalid[slot] <= 1'b1;
            last_q       <= din;
            tmr          <= '0;
            state        <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (wr_act || wr_end) begin
            tmr <= '0;
            if (wr_end && addr_q[ADDR_W-1:PAGE_W] == tag_q) begin
              pbuf[slot]   <= din;
              pvalid[slot] <= 1'b1;
              last_q       <= din;
            end
          end else if (tmr == LT_W'(LOAD_TIMEOUT - 1)) begin
            pc    <= '0;
            state <= S_PROG;
          end else begin
            tmr <= tmr + LT_W'(1);
          end
        end
        default: begin
          if (pc == PC_W'(PROG_CYCLES - 1)) begin
            for (int i = 0; i < PAGE_BYTES; i++)
              if (pvalid[i]) mem[{tag_q, PAGE_W'(i)}] <= pbuf[i];
            pvalid <= '0;
            state  <= S_IDLE;
          end else begin
            pc <= pc + PC_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eeprom_bus_seq_chk.sv
module eeprom_bus_seq_chk #(
  parameter int LOAD_TIMEOUT = 200,
  parameter int PROG_CYCLES  = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic dout_en,
  input logic rdy_pull_low
);
  localparam int QW = $clog2(LOAD_TIMEOUT + 1);
  localparam int BW = $clog2(PROG_CYCLES + 1);

  logic          win_q;
  logic [QW-1:0] quiet;
  logic [BW-1:0] blen;
  wire win = ~ce_n & ~we_n & oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      quiet <= '0;
      blen  <= '0;
    end else begin
      win_q <= win;
      if (win || win_q) quiet <= '0;
      else if (quiet != QW'(LOAD_TIMEOUT)) quiet <= quiet + QW'(1);
      if (!rdy_pull_low) blen <= '0;
      else if (blen != BW'(PROG_CYCLES)) blen <= blen + BW'(1);
    end
  end

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !dout_en); // R2
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_en); // R3
  AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_pull_low) |-> $past(quiet) == QW'(LOAD_TIMEOUT - 1)); // R7
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_pull_low) |-> $past(blen) == BW'(PROG_CYCLES - 1)); // R8
endmodule

bind eeprom_bus_seq eeprom_bus_seq_chk #(
  .LOAD_TIMEOUT(LOAD_TIMEOUT),
  .PROG_CYCLES (PROG_CYCLES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout_en(dout_en), .rdy_pull_low(rdy_pull_low)
);

// File: tb/eeprom_bus_seq_tb.sv
`timescale 1ns/1ps
module eeprom_bus_seq_tb_top;
  localparam int T = 20;
  localparam int P = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  dout;
  logic        dout_en, rdy_pull_low;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] ref_mem [2048];
  logic [7:0] pend_d [64];
  logic       pend_v [64];
  logic [4:0] pend_tag;
  bit         loading = 0;

  // {chip-select-led, addr, data}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 11'h0C0, 8'h11}, {1'b1, 11'h0C1, 8'h22},
    {1'b0, 11'h0FF, 8'h33}, {1'b1, 11'h145, 8'h44},
    {1'b0, 11'h0C1, 8'h55}, {1'b1, 11'h0E7, 8'h00},
    {1'b0, 11'h0D0, 8'h80}, {1'b1, 11'h0C0, 8'h7F}};

  eeprom_bus_seq #(.LOAD_TIMEOUT(T), .PROG_CYCLES(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .dout(dout), .dout_en(dout_en),
    .rdy_pull_low(rdy_pull_low));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [10:0] a, input logic [7:0] d);
    if (!loading) begin
      for (int i = 0; i < 64; i++) pend_v[i] = 1'b0;
      pend_tag = a[10:6];
      loading = 1;
    end
    if (a[10:6] == pend_tag) begin
      pend_d[a[5:0]] = d;
      pend_v[a[5:0]] = 1'b1;
    end
  endtask

  task automatic model_commit();
    for (int i = 0; i < 64; i++)
      if (pend_v[i]) ref_mem[{pend_tag, i[5:0]}] = pend_d[i];
    loading = 0;
  endtask

  task automatic write_w(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 1; addr = a ^ 11'h7FF; din = ~d;
    @(negedge clk); we_n = 0; addr = a; din = d;
    @(negedge clk); addr = a ^ 11'h3C0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; din = ~d;
  endtask

  task automatic write_e(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1; we_n = 0; oe_n = 1; addr = a ^ 11'h7FF; din = d;
    @(negedge clk); ce_n = 0; addr = a;
    @(negedge clk); addr = a ^ 11'h3C0;
    @(negedge clk); ce_n = 1;
    @(negedge clk); we_n = 1; din = ~d;
  endtask

  task automatic read_byte(input logic [10:0] a, output logic [7:0] d, output logic en);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    #1; d = dout; en = dout_en;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 5000 && !rdy_pull_low; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    #1;
    for (int i = 0; i < 5000 && rdy_pull_low; i++) begin n++; @(negedge clk); #1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, s1, s2;
    logic en;
    int n;
    for (int i = 0; i < 2048; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 busy after reset", {7'd0, rdy_pull_low}, 8'd0);
    check("R2 idle bus no drive", {7'd0, dout_en}, 8'd0);
    read_byte(11'h000, d, en); check("R1 array erased low", d, 8'hFF);
    check("R2 read drives", {7'd0, en}, 8'd1);
    read_byte(11'h7FF, d, en); check("R1 array erased high", d, 8'hFF);
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; #1;
    check("R2 oe_n high releases", {7'd0, dout_en}, 8'd0);
    @(negedge clk); ce_n = 1; oe_n = 0; #1;
    check("R2 ce_n high releases", {7'd0, dout_en}, 8'd0);
    @(negedge clk); oe_n = 1;

    // table walk: R4 R5 R6 R11
    for (int k = 0; k < 8; k++) begin
      if (VEC[k][19]) write_e(VEC[k][18:8], VEC[k][7:0]);
      else            write_w(VEC[k][18:8], VEC[k][7:0]);
      model_write(VEC[k][18:8], VEC[k][7:0]);
    end
    repeat (T - 1) @(negedge clk); #1;
    check("R7 not busy before timeout", {7'd0, rdy_pull_low}, 8'd0);
    @(negedge clk); #1;
    check("R7 busy after timeout", {7'd0, rdy_pull_low}, 8'd1);
    wait_idle(n);
    check("R8 busy length", 8'(n), 8'(P));
    model_commit();
    for (int i = 0; i < 64; i++) begin
      read_byte({5'd3, i[5:0]}, d, en);
      check("R6 R4 R5 page readback", d, ref_mem[{5'd3, i[5:0]}]);
    end
    read_byte(11'h145, d, en); check("R11 foreign page ignored", d, 8'hFF);

    // R6 read during loading shows old data
    write_w(11'h28A, 8'h3C); model_write(11'h28A, 8'h3C);
    read_byte(11'h28A, d, en); check("R6 read while loading old", d, 8'hFF);
    wait_busy(); wait_idle(n); model_commit();
    read_byte(11'h28A, d, en); check("R6 single byte commit", d, 8'h3C);

    // R9 R10 R12 polling and writes while busy
    write_e(11'h505, 8'hA5); model_write(11'h505, 8'hA5);
    wait_busy();
    read_byte(11'h505, s1, en);
    read_byte(11'h505, s2, en);
    check("R9 polled bit7 inverted", {7'd0, s1[7]}, 8'd0);
    check("R9 load expired bit5", {7'd0, s1[5]}, 8'd1);
    check("R10 toggle bit flips", {7'd0, s1[6] ^ s2[6]}, 8'd1);
    write_w(11'h506, 8'h12);
    write_w(11'h505, 8'h00);
    wait_idle(n); model_commit();
    read_byte(11'h505, d, en); check("R12 busy write no effect on page", d, 8'hA5);
    read_byte(11'h506, d, en); check("R12 busy write not stored", d, 8'hFF);
    check("R12 no new cycle", {7'd0, rdy_pull_low}, 8'd0);

    // R3 strobe with oe_n low is not a write
    @(negedge clk); addr = 11'h333; din = 8'h99; ce_n = 0; oe_n = 0; we_n = 0;
    repeat (3) @(negedge clk);
    ce_n = 1; oe_n = 1; we_n = 1;
    repeat (T + 5) @(negedge clk); #1;
    check("R3 no programming started", {7'd0, rdy_pull_low}, 8'd0);
    read_byte(11'h333, d, en); check("R3 no byte stored", d, 8'hFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule